// File: doc/BRIEF.md
# I2C Target with Timed Write Cycle

This block is a byte-oriented I2C target that runs entirely on a fast system clock. SCL and SDA are passed through a synchronizer and scanned for bus events: a START opens a transaction, the first byte names a 7-bit device address and a direction bit, and a matching address is acknowledged. The output side of the bus is modelled as an active-high pull-down request, so the pad is open-drain outside the block.

In a write, the first data byte sets an internal byte pointer. Later bytes go out on a byte-wide memory port at that pointer, and the pointer steps forward after each one. In a read, bytes are fetched from the memory port at the pointer and shifted out MSB first. The pointer steps forward on each master acknowledge. A STOP that closes a write starts a fixed-length internal write cycle. While that cycle runs, the block reports busy and ignores the bus completely. A sideband lock flag reports whether the last address phase selected this target. The device address can be reloaded from a configuration input.

Top module: `i2c_wc_target`

## Requirements
- R1: Bits clocked on the bus are ignored until a START is seen, where a START is SDA falling while SCL is high and a STOP is SDA rising while SCL is high. A STOP returns the block to idle.
- R2: The first byte after START carries the device address MSB first in bits 7..1 and the direction in bit 0, with 1 meaning read. On a match the block pulls SDA low for the 9th SCL pulse. The reset address is 0x54.
- R3: An address match sets if_locked_o. A mismatch clears it, gives no acknowledge and ignores all bytes until the next START.
- R4: A cfg_load_i pulse replaces the device address with cfg_addr_i. The old address is no longer acknowledged.
- R5: In a write, the first data byte loads the byte pointer. Each later byte produces one mem_we_o pulse with mem_addr_o equal to the pointer, and the pointer then increments. Every write byte is acknowledged.
- R6: In a read, bytes are taken from mem_rdata_i at the pointer and sent MSB first. The pointer increments when the master acknowledges. After a master NACK, SDA stays released until the next START or STOP.
- R7: A STOP that ends an addressed write holds busy_o high for exactly WCYC_CLKS system clocks. A STOP that ends a read does not raise busy_o.
- R8: A START that arrives while busy_o is high is discarded, so the address byte that follows is not acknowledged.
- R9: After reset, sda_drive_low_o, mem_we_o, busy_o and if_locked_o are low.
- R10: SDA is pulled low only during an acknowledge slot or a read data bit, and never while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low_o | output | 1 | Pull SDA low when high |
| cfg_load_i | input | 1 | Load a new device address |
| cfg_addr_i | input | 7 | Device address to load |
| mem_addr_o | output | PTR_W | Byte pointer for the memory port |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | One-clock write strobe |
| mem_rdata_i | input | 8 | Read data at mem_addr_o, combinational |
| busy_o | output | 1 | Internal write cycle in progress |
| if_locked_o | output | 1 | Last address phase matched |

## Verification
The hardest situation to reach is a START that lands inside the internal write cycle. The cycle lasts only a few dozen system clocks, while a single bus bit takes dozens of clocks. The bench therefore closes a write with a STOP and issues a START plus address within the busy window. It then expects no acknowledge, even though the busy window closes partway through the address byte. A full sweep of all 128 addresses checks acknowledge and lock state for each one. The busy length is counted cycle by cycle from the STOP edge.

// File: rtl/i2c_wc_pkg.sv
package i2c_wc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK, ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_wc_line_sync.sv
module i2c_wc_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // bit 1 = scl, bit 0 = sda
  logic [1:0] stg [STAGES];
  logic [1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      stg[0] <= {scl_i, sda_i};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign scl_o      = stg[STAGES-1][1];
  assign sda_o      = stg[STAGES-1][0];
  assign scl_rise_o = scl_o & ~prev_q[1];
  assign scl_fall_o = ~scl_o & prev_q[1];
  assign start_o    = scl_o & prev_q[1] & prev_q[0] & ~sda_o;
  assign stop_o     = scl_o & prev_q[1] & ~prev_q[0] & sda_o;

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((start_o || stop_o) && (scl_rise_o || scl_fall_o))); // R1
endmodule

// File: rtl/i2c_wc_timer.sv
module i2c_wc_timer #(
  parameter int unsigned CLKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CLKS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CLKS);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_NO_RELAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i); // R7
endmodule

// File: rtl/i2c_wc_target.sv
module i2c_wc_target
  import i2c_wc_pkg::*;
#(
  parameter int unsigned PTR_W        = 8,
  parameter int unsigned WCYC_CLKS    = 64,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [6:0]  RST_DEV_ADDR = 7'h54
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_drive_low_o,
  input  logic             cfg_load_i,
  input  logic [6:0]       cfg_addr_i,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             mem_we_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             busy_o,
  output logic             if_locked_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic start_ok, stop_ok, wc_launch;

  tgt_state_e     st_q;
  logic [3:0]     cnt_q;
  logic [7:0]     sh_q;
  logic [6:0]     dev_addr_q;
  logic [PTR_W-1:0] ptr_q;
  logic           rw_q, wr_txn_q, ptr_phase_q, inc_pend_q, ack_ok_q;

  i2c_wc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  // bus is ignored entirely during the write cycle
  assign start_ok  = start_det & ~busy_o;
  assign stop_ok   = stop_det & ~busy_o;
  assign wc_launch = stop_ok & wr_txn_q;

  i2c_wc_timer #(.CLKS(WCYC_CLKS)) u_timer (
    .clk_i, .rst_ni, .start_i(wc_launch), .busy_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dev_addr_q <= RST_DEV_ADDR;
    else if (cfg_load_i) dev_addr_q <= cfg_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; ptr_q <= '0;
      rw_q <= 1'b0; wr_txn_q <= 1'b0; ptr_phase_q <= 1'b0; inc_pend_q <= 1'b0;
      ack_ok_q <= 1'b0; sda_drive_low_o <= 1'b0; mem_we_o <= 1'b0;
      mem_wdata_o <= '0; if_locked_o <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      if (start_ok) begin
        st_q <= ST_ADDR; cnt_q <= '0; sda_drive_low_o <= 1'b0; wr_txn_q <= 1'b0;
      end else if (stop_ok) begin
        st_q <= ST_IDLE; sda_drive_low_o <= 1'b0; wr_txn_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q <= {sh_q[6:0], sda_s}; cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (sh_q[7:1] == dev_addr_q) begin
                st_q <= ST_ADDR_ACK; sda_drive_low_o <= 1'b1; if_locked_o <= 1'b1;
                rw_q <= sh_q[0]; wr_txn_q <= ~sh_q[0];
              end else begin
                st_q <= ST_WAIT; if_locked_o <= 1'b0;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              st_q <= ST_RD_BYTE; sh_q <= mem_rdata_i; sda_drive_low_o <= ~mem_rdata_i[7];
            end else begin
              st_q <= ST_WR_BYTE; sda_drive_low_o <= 1'b0; ptr_phase_q <= 1'b1;
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise) begin
              sh_q <= {sh_q[6:0], sda_s}; cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              st_q <= ST_WR_ACK; sda_drive_low_o <= 1'b1;
              if (ptr_phase_q) begin
                ptr_q <= PTR_W'(sh_q); ptr_phase_q <= 1'b0;
              end else begin
                mem_we_o <= 1'b1; mem_wdata_o <= sh_q; inc_pend_q <= 1'b1;
              end
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            st_q <= ST_WR_BYTE; cnt_q <= '0; sda_drive_low_o <= 1'b0;
            if (inc_pend_q) begin
              ptr_q <= ptr_q + 1'b1; inc_pend_q <= 1'b0;
            end
          end
          ST_RD_BYTE: if (scl_fall) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 4'd7) begin
              st_q <= ST_RD_ACK; sda_drive_low_o <= 1'b0;
            end else begin
              sh_q <= {sh_q[6:0], 1'b0}; sda_drive_low_o <= ~sh_q[6];
            end
          end
          ST_RD_ACK: begin
            // pointer moves at the ack rise so read data settles before the fall
            if (scl_rise) begin
              ack_ok_q <= ~sda_s;
              if (!sda_s) ptr_q <= ptr_q + 1'b1;
            end else if (scl_fall) begin
              if (ack_ok_q) begin
                st_q <= ST_RD_BYTE; cnt_q <= '0;
                sh_q <= mem_rdata_i; sda_drive_low_o <= ~mem_rdata_i[7];
              end else begin
                st_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_addr_o = ptr_q;

  AST_START_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_det) |=> st_q == ST_IDLE); // R8
  AST_QUIET_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_drive_low_o); // R10
  AST_DRIVE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_drive_low_o |-> st_q inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD_BYTE}); // R10
  AST_LOCK_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(if_locked_o) |-> st_q == ST_ADDR_ACK); // R3
  AST_WE_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> st_q == ST_WR_ACK); // R5
  AST_LAUNCH_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_det)); // R7
endmodule

// File: tb/i2c_wc_target_tb.sv
module i2c_wc_target_tb_top;
  localparam int WC = 64;
  localparam int Q  = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, cfg_load, drv, we, busy, locked;
  logic [6:0] cfg_addr;
  logic [7:0] maddr, wdata, rdata;
  logic [7:0] mem [256];
  wire sda_line = sda_m & ~drv;

  int checks = 0, failures = 0;

  i2c_wc_target #(.WCYC_CLKS(WC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low_o(drv), .cfg_load_i(cfg_load), .cfg_addr_i(cfg_addr),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_rdata_i(rdata),
    .busy_o(busy), .if_locked_o(locked)
  );

  assign rdata = mem[maddr];
  always @(posedge clk) if (we) mem[maddr] <= wdata;

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = nack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int cnt;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 0; scl_m = 1; sda_m = 1; cfg_load = 0; cfg_addr = 7'h00;
    tick(5); rst_n = 1; tick(2);
    check({drv, we, busy, locked} == 4'b0, "R9 reset", {drv, we, busy, locked}, 0);

    // R1: bits without START are ignored
    scl_m = 0; tick(Q);
    send_byte({7'h54, 1'b0}, ack);
    check(ack == 1'b1, "R1 no start no ack", ack, 1);
    scl_m = 1; tick(Q);

    // R2/R3: sweep all addresses
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, ack);
      check(ack == (a != 'h54), "R2 address ack", ack, a != 'h54);
      check(locked == (a == 'h54), "R3 lock flag", locked, a == 'h54);
      if (a == 'h55) begin
        send_byte(8'h00, ack);
        check(ack == 1'b1, "R3 ignored after mismatch", ack, 1);
      end
      bus_stop();
      tick(WC + 20);
    end

    // R5/R7: pointer + 4 data bytes, measure busy length
    bus_start();
    send_byte({7'h54, 1'b0}, ack);
    send_byte(8'h10, ack);
    check(ack == 1'b0, "R5 pointer ack", ack, 0);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'hA5 ^ (i * 37)), ack);
      check(ack == 1'b0, "R5 data ack", ack, 0);
    end
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1;
    cnt = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (busy) cnt++; end
    check(cnt == WC, "R7 busy length", cnt, WC);
    for (int i = 0; i < 4; i++)
      check(mem[8'h10 + i] == 8'(8'hA5 ^ (i * 37)), "R5 memory write",
            mem[8'h10 + i], 8'(8'hA5 ^ (i * 37)));

    // R8: pointer-only write, START inside the busy window
    bus_start();
    send_byte({7'h54, 1'b0}, ack);
    send_byte(8'h10, ack);
    bus_stop();
    check(busy == 1'b1, "R7 busy after write stop", busy, 1);
    bus_start();
    send_byte({7'h54, 1'b0}, ack);
    check(ack == 1'b1, "R8 start during busy dropped", ack, 1);
    bus_stop();
    tick(5);
    check(busy == 1'b0, "R7 no busy without write", busy, 0);

    // R6: read back with incrementing pointer
    bus_start();
    send_byte({7'h54, 1'b1}, ack);
    check(ack == 1'b0, "R2 read address ack", ack, 0);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i == 3, b);
      check(b == 8'(8'hA5 ^ (i * 37)), "R6 read data", b, 8'(8'hA5 ^ (i * 37)));
    end
    recv_byte(1'b1, b);
    check(b == 8'hFF, "R6 released after nack", b, 8'hFF);
    bus_stop();
    tick(5);
    check(busy == 1'b0, "R7 read stop no busy", busy, 0);

    // R4: reload address
    cfg_addr = 7'h23; cfg_load = 1; tick(1); cfg_load = 0;
    bus_start();
    send_byte({7'h54, 1'b0}, ack);
    check(ack == 1'b1, "R4 old address nack", ack, 1);
    bus_stop();
    bus_start();
    send_byte({7'h23, 1'b0}, ack);
    check(ack == 1'b0, "R4 new address ack", ack, 0);
    bus_stop();
    tick(WC + 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule